// File: doc/BRIEF.md
# Two-Level Local History Branch Direction Predictor

This block predicts whether a conditional branch will be taken using the branch's own recent outcomes. The first level is a table of per-branch history shift registers, selected by low bits of the branch address (the two byte-offset bits are dropped because instructions are word aligned). The second level is a table of 2-bit saturating counters. It is selected by the history read from the first level, with a few low address bits placed above it. When the number of address bits in that index is zero, every branch shares one counter table.

The fetch stage presents a PC and gets a taken/not-taken decision in the same cycle, along with the history value that was used. The execute stage later sends the resolved branch PC, the actual outcome and that saved history value back on the update port. The update shifts the outcome into the branch's history entry and moves the selected counter one step toward the outcome. Target prediction, repair of speculative state and flush handling are not part of this block.

Top module: `local_hist_pred`

## Requirements
- R1: After reset every history entry is zero and every counter holds 01 (weakly not-taken), so every PC predicts not-taken and reports history 0.
- R2: The history entry is selected by PC bits [HIST_IDX_W+1:2]; PC bits [1:0] and all bits above HIST_IDX_W+1 do not affect the selection.
- R3: A valid update shifts the history entry left by one, putting the resolved outcome (1 = taken) in bit 0 and discarding the top bit.
- R4: The counter index is {pc[PC_SEL_W+1:2], history}, with the history in the low HIST_LEN bits. When PC_SEL_W is 0 the index is the history alone.
- R5: pred_taken is 1 exactly when the selected counter is 10 or 11.
- R6: A valid update increments the selected counter when the outcome is taken and decrements it when not-taken, saturating at 11 and 00.
- R7: On update, the counter is selected with the upd_hist value supplied on the port, not with the history currently stored for upd_pc.
- R8: The prediction outputs depend combinationally on pred_pc and the stored state. An update written in cycle N becomes visible to predictions from cycle N+1; a prediction in cycle N sees the state from before that update.
- R9: When upd_valid is 0, neither table changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_LEN | Local history used for this prediction, to be returned with the update |
| upd_valid | input | 1 | Update request strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | HIST_LEN | History that was reported with this branch's prediction |

## Verification
Every cycle, assertions check the history shift on an update and the direction of each counter step. They also check saturation at both ends and that both tables stay frozen when no update is requested. Only the bench scenarios can show the rest. These are the reset contents, the way address bits select entries (offset bits ignored, aliasing, the shared table when no address bits are used), and the use of the supplied history rather than the stored one. They also include the same-cycle prediction-before-update ordering and the learning of repeating patterns. The bench checks all of this by comparing against a reference model on every cycle for both the default configuration and the shared-table configuration.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // One saturating step of a 2-bit counter toward the outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // Direction decision from a counter value
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int PC_W       = 32,
  parameter int HIST_IDX_W = 4,
  parameter int HIST_LEN   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     rd_pc,
  output logic [HIST_LEN-1:0] rd_hist,
  input  logic                wr_en,
  input  logic [PC_W-1:0]     wr_pc,
  input  logic                wr_taken
);
  localparam int ENTRIES = 1 << HIST_IDX_W;

  logic [ENTRIES-1:0][HIST_LEN-1:0] hist_q;
  logic [HIST_IDX_W-1:0] rd_idx;
  logic [HIST_IDX_W-1:0] wr_idx;
  logic [HIST_LEN-1:0]   wr_old;
  logic [HIST_LEN-1:0]   wr_new;

  // Word-aligned hash: byte-offset bits are skipped
  assign rd_idx  = rd_pc[HIST_IDX_W+1:2];
  assign wr_idx  = wr_pc[HIST_IDX_W+1:2];
  assign rd_hist = hist_q[rd_idx];
  assign wr_old  = hist_q[wr_idx];

  generate
    if (HIST_LEN == 1) begin : g_one_bit
      assign wr_new = wr_taken;
    end else begin : g_shift
      assign wr_new = {wr_old[HIST_LEN-2:0], wr_taken};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_new;
    end
  end

  // R3
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_taken));

  generate
    if (HIST_LEN > 1) begin : g_shift_chk
      // R3
      hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][HIST_LEN-1:1] == $past(wr_old[HIST_LEN-2:0]));
    end
  endgenerate

  // R9
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hist_q));

endmodule

// File: rtl/lhp_index_gen.sv
module lhp_index_gen #(
  parameter int PC_W      = 32,
  parameter int PC_SEL_W  = 2,
  parameter int HIST_LEN  = 4,
  localparam int IDX_W    = PC_SEL_W + HIST_LEN
) (
  input  logic [PC_W-1:0]     pc,
  input  logic [HIST_LEN-1:0] hist,
  output logic [IDX_W-1:0]    idx
);
  generate
    if (PC_SEL_W == 0) begin : g_shared
      // All branches share a single counter table
      assign idx = hist;
    end else begin : g_per_addr
      assign idx = {pc[PC_SEL_W+1:2], hist};
    end
  endgenerate
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0][1:0] ctr_q;
  ctr_t wr_old;
  ctr_t wr_new;

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

  // R6
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old != CTR_MAX) |=> ctr_q[$past(wr_idx)] == $past(wr_old) + 2'd1);

  // R6
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old != CTR_MIN) |=> ctr_q[$past(wr_idx)] == $past(wr_old) - 2'd1);

  // R6
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);

  // R6
  ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);

  // R9
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/local_hist_pred.sv
module local_hist_pred
  import lhp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int HIST_IDX_W = 4,
  parameter int HIST_LEN   = 4,
  parameter int PC_SEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     pred_pc,
  output logic                pred_taken,
  output logic [HIST_LEN-1:0] pred_hist,
  input  logic                upd_valid,
  input  logic [PC_W-1:0]     upd_pc,
  input  logic                upd_taken,
  input  logic [HIST_LEN-1:0] upd_hist
);
  localparam int PT_IDX_W = PC_SEL_W + HIST_LEN;

  logic [HIST_LEN-1:0] rd_hist;
  logic [PT_IDX_W-1:0] rd_pt_idx;
  logic [PT_IDX_W-1:0] wr_pt_idx;
  ctr_t                rd_ctr;

  lhp_hist_table #(
    .PC_W(PC_W), .HIST_IDX_W(HIST_IDX_W), .HIST_LEN(HIST_LEN)
  ) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(pred_pc), .rd_hist(rd_hist),
    .wr_en(upd_valid), .wr_pc(upd_pc), .wr_taken(upd_taken)
  );

  lhp_index_gen #(
    .PC_W(PC_W), .PC_SEL_W(PC_SEL_W), .HIST_LEN(HIST_LEN)
  ) u_rd_idx (
    .pc(pred_pc), .hist(rd_hist), .idx(rd_pt_idx)
  );

  // The update is steered by the history captured at prediction time
  lhp_index_gen #(
    .PC_W(PC_W), .PC_SEL_W(PC_SEL_W), .HIST_LEN(HIST_LEN)
  ) u_wr_idx (
    .pc(upd_pc), .hist(upd_hist), .idx(wr_pt_idx)
  );

  lhp_pattern_table #(
    .IDX_W(PT_IDX_W)
  ) u_pattern (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_pt_idx), .rd_ctr(rd_ctr),
    .wr_en(upd_valid), .wr_idx(wr_pt_idx), .wr_taken(upd_taken)
  );

  assign pred_taken = ctr_says_taken(rd_ctr);
  assign pred_hist  = rd_hist;

  // R8
  pred_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({pred_taken, pred_hist}));

endmodule

// File: tb/test_local_hist_pred.sv
module test_local_hist_pred;
  localparam int PC_W = 32;
  localparam int L1W  = 4;
  localparam int HL   = 4;
  localparam int MSEL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_taken = 1'b0;
  logic [HL-1:0] upd_hist = '0;
  logic p_taken [2];
  logic [HL-1:0] p_hist [2];

  always #2.5 clk = ~clk;

  local_hist_pred #(.PC_W(PC_W), .HIST_IDX_W(L1W), .HIST_LEN(HL), .PC_SEL_W(MSEL))
  i_local_hist_pred (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p_taken[0]),
    .pred_hist(p_hist[0]), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist));

  // Second instance with no address bits in the counter index (shared table)
  local_hist_pred #(.PC_W(PC_W), .HIST_IDX_W(L1W), .HIST_LEN(HL), .PC_SEL_W(0))
  i_local_hist_pred_shared (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p_taken[1]),
    .pred_hist(p_hist[1]), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist));

  // Reference model state: [config][entry]
  int m_hist [2][16];
  int m_ctr  [2][64];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic int l1_of(input logic [PC_W-1:0] pc);
    return int'((pc >> 2) % 16);
  endfunction

  function automatic int pt_of(input int k, input logic [PC_W-1:0] pc, input int h);
    if (k == 1) return h;
    return int'((pc >> 2) % 4) * 16 + h;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 16; i++) m_hist[k][i] = 0;
      for (int i = 0; i < 64; i++) m_ctr[k][i] = 1;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle: inputs set after negedge, outputs compared, model advanced
  task automatic step(input string tag, input logic [PC_W-1:0] ppc, input bit uv,
                      input logic [PC_W-1:0] upc, input bit ut, input int uh);
    pred_pc   = ppc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    upd_hist  = HL'(uh);
    #1;
    for (int k = 0; k < 2; k++) begin
      int h;
      int c;
      h = m_hist[k][l1_of(ppc)];
      c = m_ctr[k][pt_of(k, ppc, h)];
      check(tag, int'(p_hist[k]), h, k == 0 ? "hist" : "hist(shared)");
      check(tag, int'(p_taken[k]), (c >= 2) ? 1 : 0, k == 0 ? "taken" : "taken(shared)");
    end
    if (uv) begin
      for (int k = 0; k < 2; k++) begin
        int pi;
        int li;
        pi = pt_of(k, upc, uh);
        if (ut) m_ctr[k][pi] = (m_ctr[k][pi] == 3) ? 3 : m_ctr[k][pi] + 1;
        else    m_ctr[k][pi] = (m_ctr[k][pi] == 0) ? 0 : m_ctr[k][pi] - 1;
        li = l1_of(upc);
        m_hist[k][li] = ((m_hist[k][li] << 1) | int'(ut)) % 16;
      end
    end
    @(negedge clk);
  endtask

  // Resolve a branch with the history the model currently holds for it
  task automatic resolve(input string tag, input logic [PC_W-1:0] pc, input bit t);
    step(tag, pc, 1'b1, pc, t, m_hist[0][l1_of(pc)]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents across every first-level entry and offset
    for (int i = 0; i < 64; i++) step("R1", PC_W'(i * 4 + (i % 4)), 0, '0, 0, 0);
    // R1: a single taken update from weakly not-taken flips the counter
    step("R1", 32'h100, 1, 32'h100, 1, 0);
    step("R1", 32'h100, 0, '0, 0, 0);

    // R3: outcome sequence shifts through the history
    resolve("R3", 32'h140, 1);
    resolve("R3", 32'h140, 0);
    resolve("R3", 32'h140, 1);
    resolve("R3", 32'h140, 1);
    resolve("R3", 32'h140, 0);
    step("R3", 32'h140, 0, '0, 0, 0);

    // R2: offset bits and upper bits alias onto the same history entry
    resolve("R2", 32'h200, 1);
    step("R2", 32'h203, 0, '0, 0, 0);
    step("R2", 32'h201, 0, '0, 0, 0);
    step("R2", 32'hABC0_0200, 0, '0, 0, 0);
    step("R2", 32'h204, 0, '0, 0, 0);

    // R6: saturate high, then low, with a fixed history
    for (int i = 0; i < 6; i++) step("R6", 32'h300, 1, 32'h300, 1, 5);
    for (int i = 0; i < 6; i++) step("R6", 32'h300, 1, 32'h300, 0, 5);
    step("R6", 32'h300, 0, '0, 0, 0);

    // R7: supplied history differs from stored history
    for (int i = 0; i < 3; i++) step("R7", 32'h308, 1, 32'h308, 1, 9);
    for (int h = 0; h < 16; h++) step("R7", 32'h308, 0, '0, 0, 0);

    // R4/R5: per-address bits separate counters; shared table does not
    for (int i = 0; i < 4; i++) step("R4", 32'h400, 1, 32'h404, 1, 0);
    step("R4", 32'h400, 0, '0, 0, 0);
    step("R5", 32'h404, 0, '0, 0, 0);

    // R8: same-cycle predict and update on one branch sees the old state
    for (int i = 0; i < 8; i++) resolve("R8", 32'h500, (i % 2) == 0);

    // R9: strobe low with busy update fields changes nothing
    for (int i = 0; i < 20; i++)
      step("R9", PC_W'(i * 4), 0, PC_W'(i * 4), 1, i % 16);

    // R5: loop branch taken three times then exits, learned via local history
    for (int i = 0; i < 48; i++) resolve("R5", 32'h600, (i % 4) != 3);

    // R4: mixed random traffic over a small set of branches
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] pp;
      logic [PC_W-1:0] up;
      pp = PC_W'(($urandom % 32) * 4 + ($urandom % 4));
      up = PC_W'(($urandom % 32) * 4);
      step("R4", pp, ($urandom % 4) != 0, up, $urandom % 2, int'($urandom % 16));
    end

    // R1: reset again mid-run restores the initial contents
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 16; i++) step("R1", PC_W'(i * 4), 0, '0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule